// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block decides, cycle by cycle, what the fetch stage of a multithreaded core may do for each hardware thread. For every thread it keeps four sticky stall flags, one per downstream stage (decode, rename, execute and commit). It combines those flags with a global context-switch stall and with the squash requests arriving from commit and from decode. From all of this it produces a registered status code for the thread. When a squash redirects the thread, the block also holds the thread's PC and the two PCs that follow it.

The block does not issue memory requests itself. The instruction-line requester and the fetch sequencer report their outcomes as per-thread event pulses:
- a request was refused for lack of resources
- a request was accepted
- a response arrived
- the thread received a fetch slot
- the thread must wait for a trap or a quiesce
- the thread is parked
- the thread is woken

A single stage-level flag tells the core whether fetch has any useful work in any thread. Threads whose `thread_active` bit is low are frozen.

Top module: `fetch_status_ctrl`

## Requirements
- R1: Synchronous active-high reset puts every thread in Running with PC = RESET_PC, next PC = RESET_PC+4 and next-next PC = RESET_PC+8, and clears all stall flags. Status codes on `thr_state` are: 0 Running, 1 Idle, 2 Squashing, 3 Blocked, 4 wait-retry, 5 wait-response, 6 access-complete, 7 trap-pending, 8 quiesce-pending.
- R2: Bit s*NT+t of `stage_block` sets thread t's sticky stall flag for stage s, where stage 0 is decode, 1 rename, 2 execute and 3 commit. The same bit of `stage_unblock` clears that flag. The flag persists between the two pulses. An unblock pulse is illegal unless the flag is set and no block pulse for the same flag arrives in the same cycle.
- R3: A commit squash has the highest priority. In the next cycle the thread is Squashing, with PC = target, next PC = target+4 and next-next PC = target+8. This holds in any state, even when a decode squash, a stall or an event arrives in the same cycle.
- R4: Without a commit squash, a thread whose reorder buffer is still squashing is Squashing in the next cycle and keeps its PCs unchanged. This takes precedence over a decode squash and over any stall.
- R5: A decode squash redirects the PCs in the same way as R3, but only when the thread is not already Squashing. When the thread is already Squashing, the decode squash is ignored.
- R6: When no squash applies, any stall flag or `ctx_switch` moves the thread to Blocked. The flag value used is the one after this cycle's block and unblock pulses. The exceptions are wait-response, trap-pending and quiesce-pending, where the state is kept.
- R7: A thread in Blocked or Squashing with no squash and no stall in a cycle is Running in the next cycle.
- R8: From Running, a refused request leads to wait-retry and an accepted request leads to wait-response. From wait-retry, an accepted request leads to wait-response. A response in wait-response leads to access-complete, or to Blocked if a stall is active in that cycle. A response pulse in any other state has no effect.
- R9: Access-complete stays put until the thread's fetch slot pulse, after which the thread is Running.
- R10: From Running, the trap, quiesce and park pulses (in that priority, ahead of the request events) lead to trap-pending, quiesce-pending and Idle. Trap-pending, quiesce-pending and Idle are left only by a squash or by a wake pulse, which returns the thread to Running.
- R11: A thread whose `thread_active` bit is low keeps its status, its PCs and its stall flags, whatever else is driven.
- R12: `stage_active` is high exactly when at least one active thread is Running, Squashing or access-complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_active | input | NT | Thread participates this cycle |
| stage_block | input | NS*NT | Block pulses, bit s*NT+t |
| stage_unblock | input | NS*NT | Unblock pulses, bit s*NT+t |
| ctx_switch | input | 1 | Global context-switch stall |
| cmt_squash | input | NT | Squash request from commit |
| cmt_rob_busy | input | NT | Reorder buffer still squashing |
| cmt_target | input | NT*AW | Commit redirect address per thread |
| dec_squash | input | NT | Squash request from decode |
| dec_target | input | NT*AW | Decode redirect address per thread |
| ev_retry | input | NT | Line request refused |
| ev_issue | input | NT | Line request accepted |
| ev_resp | input | NT | Line response arrived |
| ev_slot | input | NT | Thread received its fetch slot |
| ev_trap | input | NT | Enter trap-pending |
| ev_quiesce | input | NT | Enter quiesce-pending |
| ev_park | input | NT | Enter Idle |
| ev_wake | input | NT | Wake from Idle, trap or quiesce |
| thr_state | output | NT*4 | Status code per thread |
| thr_pc | output | NT*AW | Current PC per thread |
| thr_npc | output | NT*AW | Next PC per thread |
| thr_nnpc | output | NT*AW | Next-next PC per thread |
| stage_active | output | 1 | Fetch stage has work |

## Verification
The bench targets the collisions in the priority ladder. In one of them a commit squash, a decode squash, a reorder-buffer squash and a new block all land in the same cycle; a design with the priorities swapped would load the decode target or end up Blocked. In another, a stall arrives while a line response is outstanding; a design that does not protect wait-response would drop the pending access, and one that ignores the stall when the response arrives would report access-complete instead of Blocked. Further cases cover:
- a decode squash while the thread is already Squashing, which must not move the PC;
- a response that arrives after a squash, which must be discarded;
- trap and quiesce states that resist stalls and events until a wake or a squash;
- a frozen inactive thread that must ignore a squash aimed at it.

// File: rtl/fsc_pkg.sv
`timescale 1ns/1ps
package fsc_pkg;

    typedef enum logic [3:0] {
        ST_RUN     = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SQUASH  = 4'd2,
        ST_BLOCKED = 4'd3,
        ST_WRETRY  = 4'd4,
        ST_WRESP   = 4'd5,
        ST_ACCDONE = 4'd6,
        ST_TRAP    = 4'd7,
        ST_QUIESCE = 4'd8
    } fstate_e;

    localparam int STATE_W = 4;

    // Event pulses from the line requester and fetch sequencer for one thread.
    typedef struct packed {
        logic retry;
        logic issue;
        logic resp;
        logic slot;
        logic trap;
        logic quiesce;
        logic park;
        logic wake;
    } thr_evt_t;

    // States in which the fetch stage has useful work.
    function automatic logic has_work(fstate_e s);
        return (s == ST_RUN) || (s == ST_SQUASH) || (s == ST_ACCDONE);
    endfunction

    // States that a stall must not disturb.
    function automatic logic stall_exempt(fstate_e s);
        return (s == ST_WRESP) || (s == ST_TRAP) || (s == ST_QUIESCE);
    endfunction

endpackage

// File: rtl/fsc_stall_tracker.sv
`timescale 1ns/1ps
module fsc_stall_tracker #(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [NS-1:0] blk,
    input  logic [NS-1:0] unblk,
    input  logic          ctx_switch,
    output logic [NS-1:0] flags_q,
    output logic          stall_now
);
    logic [NS-1:0] flags_d;

    always_comb begin
        flags_d   = (flags_q | blk) & ~unblk;
        stall_now = (|flags_d) | ctx_switch;
    end

    always_ff @(posedge clk) begin
        if (rst)     flags_q <= '0;
        else if (en) flags_q <= flags_d;
    end
endmodule

// File: rtl/fsc_thread_fsm.sv
`timescale 1ns/1ps
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int          AW         = 32,
    parameter logic [AW-1:0] RESET_PC = '0,
    parameter int          INST_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          stall,
    input  logic          cmt_sq,
    input  logic          rob_busy,
    input  logic [AW-1:0] cmt_tgt,
    input  logic          dec_sq,
    input  logic [AW-1:0] dec_tgt,
    input  thr_evt_t      evt,
    output fstate_e       state_q,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] npc_q,
    output logic [AW-1:0] nnpc_q
);
    localparam logic [AW-1:0] STEP  = AW'(INST_BYTES);
    localparam logic [AW-1:0] STEP2 = AW'(2 * INST_BYTES);

    fstate_e       nxt;
    logic          redir;
    logic [AW-1:0] tgt;

    always_comb begin
        nxt   = state_q;
        redir = 1'b0;
        tgt   = cmt_tgt;
        if (cmt_sq) begin
            nxt   = ST_SQUASH;
            redir = 1'b1;
        end else if (rob_busy) begin
            nxt = ST_SQUASH;
        end else if (dec_sq && state_q != ST_SQUASH) begin
            nxt   = ST_SQUASH;
            redir = 1'b1;
            tgt   = dec_tgt;
        end else if (stall && !stall_exempt(state_q)) begin
            nxt = ST_BLOCKED;
        end else begin
            unique case (state_q)
                ST_BLOCKED, ST_SQUASH: nxt = ST_RUN;
                ST_RUN: begin
                    if (evt.trap)         nxt = ST_TRAP;
                    else if (evt.quiesce) nxt = ST_QUIESCE;
                    else if (evt.park)    nxt = ST_IDLE;
                    else if (evt.retry)   nxt = ST_WRETRY;
                    else if (evt.issue)   nxt = ST_WRESP;
                end
                ST_WRETRY:  if (evt.issue) nxt = ST_WRESP;
                ST_WRESP:   if (evt.resp)  nxt = stall ? ST_BLOCKED : ST_ACCDONE;
                ST_ACCDONE: if (evt.slot)  nxt = ST_RUN;
                ST_TRAP, ST_QUIESCE, ST_IDLE: if (evt.wake) nxt = ST_RUN;
                default: nxt = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            pc_q    <= RESET_PC;
            npc_q   <= RESET_PC + STEP;
            nnpc_q  <= RESET_PC + STEP2;
        end else if (en) begin
            state_q <= nxt;
            if (redir) begin
                pc_q   <= tgt;
                npc_q  <= tgt + STEP;
                nnpc_q <= tgt + STEP2;
            end
        end
    end
endmodule

// File: rtl/fsc_activity.sv
`timescale 1ns/1ps
module fsc_activity
    import fsc_pkg::*;
#(
    parameter int NT = 2
) (
    input  fstate_e [NT-1:0] states,
    input  logic    [NT-1:0] active,
    output logic             any_work
);
    always_comb begin
        any_work = 1'b0;
        for (int i = 0; i < NT; i++)
            any_work = any_work | (active[i] & has_work(states[i]));
    end
endmodule

// File: rtl/fetch_status_ctrl.sv
`timescale 1ns/1ps
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int            NT         = 2,
    parameter int            NS         = 4,
    parameter int            AW         = 32,
    parameter int            INST_BYTES = 4,
    parameter logic [AW-1:0] RESET_PC   = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NT-1:0]      thread_active,
    input  logic [NS*NT-1:0]   stage_block,
    input  logic [NS*NT-1:0]   stage_unblock,
    input  logic               ctx_switch,
    input  logic [NT-1:0]      cmt_squash,
    input  logic [NT-1:0]      cmt_rob_busy,
    input  logic [NT*AW-1:0]   cmt_target,
    input  logic [NT-1:0]      dec_squash,
    input  logic [NT*AW-1:0]   dec_target,
    input  logic [NT-1:0]      ev_retry,
    input  logic [NT-1:0]      ev_issue,
    input  logic [NT-1:0]      ev_resp,
    input  logic [NT-1:0]      ev_slot,
    input  logic [NT-1:0]      ev_trap,
    input  logic [NT-1:0]      ev_quiesce,
    input  logic [NT-1:0]      ev_park,
    input  logic [NT-1:0]      ev_wake,
    output logic [NT*STATE_W-1:0] thr_state,
    output logic [NT*AW-1:0]   thr_pc,
    output logic [NT*AW-1:0]   thr_npc,
    output logic [NT*AW-1:0]   thr_nnpc,
    output logic               stage_active
);
    fstate_e [NT-1:0]   st;
    logic [NS*NT-1:0]   stall_flags;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [NS-1:0] blk_t, unblk_t, flags_t;
        logic          stall_t;
        thr_evt_t      evt_t;

        for (genvar s = 0; s < NS; s++) begin : g_stage
            assign blk_t[s]             = stage_block[s*NT + t];
            assign unblk_t[s]           = stage_unblock[s*NT + t];
            assign stall_flags[s*NT + t] = flags_t[s];
        end

        assign evt_t = '{retry: ev_retry[t], issue: ev_issue[t], resp: ev_resp[t],
                         slot: ev_slot[t], trap: ev_trap[t], quiesce: ev_quiesce[t],
                         park: ev_park[t], wake: ev_wake[t]};

        fsc_stall_tracker #(.NS(NS)) u_stall (
            .clk        (clk),
            .rst        (rst),
            .en         (thread_active[t]),
            .blk        (blk_t),
            .unblk      (unblk_t),
            .ctx_switch (ctx_switch),
            .flags_q    (flags_t),
            .stall_now  (stall_t)
        );

        fsc_thread_fsm #(.AW(AW), .RESET_PC(RESET_PC), .INST_BYTES(INST_BYTES)) u_fsm (
            .clk      (clk),
            .rst      (rst),
            .en       (thread_active[t]),
            .stall    (stall_t),
            .cmt_sq   (cmt_squash[t]),
            .rob_busy (cmt_rob_busy[t]),
            .cmt_tgt  (cmt_target[t*AW +: AW]),
            .dec_sq   (dec_squash[t]),
            .dec_tgt  (dec_target[t*AW +: AW]),
            .evt      (evt_t),
            .state_q  (st[t]),
            .pc_q     (thr_pc[t*AW +: AW]),
            .npc_q    (thr_npc[t*AW +: AW]),
            .nnpc_q   (thr_nnpc[t*AW +: AW])
        );

        assign thr_state[t*STATE_W +: STATE_W] = st[t];
    end

    fsc_activity #(.NT(NT)) u_act (
        .states   (st),
        .active   (thread_active),
        .any_work (stage_active)
    );
endmodule

// File: rtl/fetch_status_ctrl_chk.sv
`timescale 1ns/1ps
module fetch_status_ctrl_chk #(
    parameter int NT = 2,
    parameter int NS = 4,
    parameter int AW = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NT-1:0]      thread_active,
    input logic [NS*NT-1:0]   stage_block,
    input logic [NS*NT-1:0]   stage_unblock,
    input logic               ctx_switch,
    input logic [NT-1:0]      cmt_squash,
    input logic [NT-1:0]      cmt_rob_busy,
    input logic [NT*AW-1:0]   cmt_target,
    input logic [NT-1:0]      dec_squash,
    input logic [NT-1:0]      ev_wake,
    input logic [NT*4-1:0]    thr_state,
    input logic [NT*AW-1:0]   thr_pc,
    input logic               stage_active,
    input logic [NS*NT-1:0]   stall_flags
);
    for (genvar i = 0; i < NS*NT; i++) begin : g_flag
        assert_unblock_legal_R2: assert property (@(posedge clk) disable iff (rst)
            stage_unblock[i] |-> (stall_flags[i] && !stage_block[i]));
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        assert_commit_redirect_R3: assert property (@(posedge clk) disable iff (rst)
            (thread_active[t] && cmt_squash[t]) |=>
            (thr_state[t*4 +: 4] == 4'd2 && thr_pc[t*AW +: AW] == $past(cmt_target[t*AW +: AW])));

        assert_rob_holds_pc_R4: assert property (@(posedge clk) disable iff (rst)
            (thread_active[t] && !cmt_squash[t] && cmt_rob_busy[t]) |=>
            (thr_state[t*4 +: 4] == 4'd2 && thr_pc[t*AW +: AW] == $past(thr_pc[t*AW +: AW])));

        assert_ctx_blocks_R6: assert property (@(posedge clk) disable iff (rst)
            (thread_active[t] && thr_state[t*4 +: 4] == 4'd0 && ctx_switch &&
             !cmt_squash[t] && !cmt_rob_busy[t] && !dec_squash[t]) |=>
            (thr_state[t*4 +: 4] == 4'd3));

        assert_trap_sticky_R10: assert property (@(posedge clk) disable iff (rst)
            (thread_active[t] && thr_state[t*4 +: 4] == 4'd7 && !cmt_squash[t] &&
             !cmt_rob_busy[t] && !dec_squash[t] && !ev_wake[t]) |=>
            (thr_state[t*4 +: 4] == 4'd7));

        assert_inactive_frozen_R11: assert property (@(posedge clk) disable iff (rst)
            !thread_active[t] |=>
            ($stable(thr_state[t*4 +: 4]) && $stable(thr_pc[t*AW +: AW])));

        assert_running_active_R12: assert property (@(posedge clk) disable iff (rst)
            (thread_active[t] && thr_state[t*4 +: 4] == 4'd0) |-> stage_active);
    end
endmodule

bind fetch_status_ctrl fetch_status_ctrl_chk #(.NT(NT), .NS(NS), .AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .thread_active (thread_active),
    .stage_block   (stage_block),
    .stage_unblock (stage_unblock),
    .ctx_switch    (ctx_switch),
    .cmt_squash    (cmt_squash),
    .cmt_rob_busy  (cmt_rob_busy),
    .cmt_target    (cmt_target),
    .dec_squash    (dec_squash),
    .ev_wake       (ev_wake),
    .thr_state     (thr_state),
    .thr_pc        (thr_pc),
    .stage_active  (stage_active),
    .stall_flags   (stall_flags)
);

// File: tb/fetch_status_ctrl_bench.sv
`timescale 1ns/1ps
module fetch_status_ctrl_bench;
    localparam int NT = 2;
    localparam int NS = 4;
    localparam int AW = 32;
    localparam logic [31:0] RPC = 32'h0000_1000;

    localparam int C_RUN = 0, C_IDLE = 1, C_SQ = 2, C_BLK = 3, C_WRETRY = 4,
                   C_WRESP = 5, C_ACC = 6, C_TRAP = 7, C_QUI = 8;

    logic clk = 1'b0;
    logic rst;
    logic [NT-1:0]    thread_active;
    logic [NS*NT-1:0] stage_block, stage_unblock;
    logic             ctx_switch;
    logic [NT-1:0]    cmt_squash, cmt_rob_busy, dec_squash;
    logic [NT*AW-1:0] cmt_target, dec_target;
    logic [NT-1:0]    ev_retry, ev_issue, ev_resp, ev_slot, ev_trap, ev_quiesce, ev_park, ev_wake;
    logic [NT*4-1:0]  thr_state;
    logic [NT*AW-1:0] thr_pc, thr_npc, thr_nnpc;
    logic             stage_active;

    fetch_status_ctrl #(.NT(NT), .NS(NS), .AW(AW), .RESET_PC(RPC)) u_fetch_status_ctrl (
        .clk(clk), .rst(rst), .thread_active(thread_active),
        .stage_block(stage_block), .stage_unblock(stage_unblock), .ctx_switch(ctx_switch),
        .cmt_squash(cmt_squash), .cmt_rob_busy(cmt_rob_busy), .cmt_target(cmt_target),
        .dec_squash(dec_squash), .dec_target(dec_target),
        .ev_retry(ev_retry), .ev_issue(ev_issue), .ev_resp(ev_resp), .ev_slot(ev_slot),
        .ev_trap(ev_trap), .ev_quiesce(ev_quiesce), .ev_park(ev_park), .ev_wake(ev_wake),
        .thr_state(thr_state), .thr_pc(thr_pc), .thr_npc(thr_npc), .thr_nnpc(thr_nnpc),
        .stage_active(stage_active)
    );

    always #2.5 clk = ~clk;

    int    compared = 0;
    int    mismatched = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // Reference model state
    int          m_st  [NT];
    logic [31:0] m_pc  [NT];
    bit          m_flag[NS][NT];
    int          n_st  [NT];
    logic [31:0] n_pc  [NT];
    bit          n_flag[NS][NT];

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit exp_act = 0;
        for (int t = 0; t < NT; t++) begin
            chk($sformatf("state[%0d]", t), 64'(thr_state[t*4 +: 4]), 64'(m_st[t]));
            chk($sformatf("pc[%0d]", t),   64'(thr_pc[t*AW +: AW]),   64'(m_pc[t]));
            chk($sformatf("npc[%0d]", t),  64'(thr_npc[t*AW +: AW]),  64'(m_pc[t] + 32'd4));
            chk($sformatf("nnpc[%0d]", t), 64'(thr_nnpc[t*AW +: AW]), 64'(m_pc[t] + 32'd8));
            if (thread_active[t] && (m_st[t] == C_RUN || m_st[t] == C_SQ || m_st[t] == C_ACC))
                exp_act = 1;
        end
        chk("stage_active", 64'(stage_active), 64'(exp_act));
    endtask

    task automatic clear_inputs();
        stage_block = '0; stage_unblock = '0; ctx_switch = 0;
        cmt_squash = '0; cmt_rob_busy = '0; dec_squash = '0;
        cmt_target = '0; dec_target = '0;
        ev_retry = '0; ev_issue = '0; ev_resp = '0; ev_slot = '0;
        ev_trap = '0; ev_quiesce = '0; ev_park = '0; ev_wake = '0;
    endtask

    task automatic model_next();
        for (int t = 0; t < NT; t++) begin
            bit stall = ctx_switch;
            int s;
            n_st[t] = m_st[t];
            n_pc[t] = m_pc[t];
            for (int g = 0; g < NS; g++) begin
                n_flag[g][t] = m_flag[g][t];
                if (thread_active[t]) begin
                    if (stage_block[g*NT + t])   n_flag[g][t] = 1;
                    if (stage_unblock[g*NT + t]) n_flag[g][t] = 0;
                end
                if (n_flag[g][t]) stall = 1;
            end
            if (!thread_active[t]) continue;
            s = m_st[t];
            if (cmt_squash[t]) begin
                n_st[t] = C_SQ; n_pc[t] = cmt_target[t*AW +: AW];
            end else if (cmt_rob_busy[t]) begin
                n_st[t] = C_SQ;
            end else if (dec_squash[t] && s != C_SQ) begin
                n_st[t] = C_SQ; n_pc[t] = dec_target[t*AW +: AW];
            end else if (stall && s != C_WRESP && s != C_TRAP && s != C_QUI) begin
                n_st[t] = C_BLK;
            end else if (s == C_BLK || s == C_SQ) begin
                n_st[t] = C_RUN;
            end else if (s == C_RUN) begin
                if (ev_trap[t])         n_st[t] = C_TRAP;
                else if (ev_quiesce[t]) n_st[t] = C_QUI;
                else if (ev_park[t])    n_st[t] = C_IDLE;
                else if (ev_retry[t])   n_st[t] = C_WRETRY;
                else if (ev_issue[t])   n_st[t] = C_WRESP;
            end else if (s == C_WRETRY) begin
                if (ev_issue[t]) n_st[t] = C_WRESP;
            end else if (s == C_WRESP) begin
                if (ev_resp[t]) n_st[t] = stall ? C_BLK : C_ACC;
            end else if (s == C_ACC) begin
                if (ev_slot[t]) n_st[t] = C_RUN;
            end else begin
                if (ev_wake[t]) n_st[t] = C_RUN;
            end
        end
    endtask

    // Inputs are set by the caller just after a falling edge.
    task automatic cycle();
        model_next();
        @(posedge clk);
        for (int t = 0; t < NT; t++) begin
            m_st[t] = n_st[t];
            m_pc[t] = n_pc[t];
            for (int g = 0; g < NS; g++) m_flag[g][t] = n_flag[g][t];
        end
        @(negedge clk);
        compare_all();
        clear_inputs();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(100000 * 5);
        mismatched++;
        $display("FAIL watchdog expired in %s", cur_req);
        report();
    end

    initial begin
        rst = 1; thread_active = '1; clear_inputs();
        for (int t = 0; t < NT; t++) begin
            m_st[t] = C_RUN; m_pc[t] = RPC;
            for (int g = 0; g < NS; g++) m_flag[g][t] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1"; compare_all();
        rst = 0;
        cycle();

        // R2: sticky rename flag on thread 0
        cur_req = "R2";
        stage_block[1*NT + 0] = 1; cycle();
        cycle(); cycle();
        stage_unblock[1*NT + 0] = 1; cycle();
        cycle();

        // R6: context switch stall, then stall held off during wait-response
        cur_req = "R6";
        ctx_switch = 1; cycle();
        cycle();
        ev_issue[0] = 1; cycle();
        stage_block[3*NT + 0] = 1; cycle();
        cycle();
        cur_req = "R8";
        ev_resp[0] = 1; cycle();
        stage_unblock[3*NT + 0] = 1; cycle();

        // R8 / R9: retry path, response, slot
        ev_retry[0] = 1; cycle();
        ev_resp[0] = 1; cycle();
        ev_issue[0] = 1; cycle();
        ev_resp[0] = 1; cycle();
        cur_req = "R9";
        cycle();
        ev_slot[0] = 1; cycle();

        // R3: all squash sources and a stall at once
        cur_req = "R3";
        cmt_squash[0] = 1; cmt_target[0 +: AW] = 32'h2000;
        dec_squash[0] = 1; dec_target[0 +: AW] = 32'h3000;
        cmt_rob_busy[0] = 1; stage_block[0*NT + 0] = 1; cycle();
        cur_req = "R7";
        cycle();
        stage_unblock[0*NT + 0] = 1; cycle();
        cur_req = "R3";
        ev_issue[0] = 1; cycle();
        cmt_squash[0] = 1; cmt_target[0 +: AW] = 32'h2400; cycle();
        cur_req = "R7";
        ev_resp[0] = 1; cycle();
        cycle();

        // R4: reorder buffer squashing beats decode squash
        cur_req = "R4";
        cmt_rob_busy[0] = 1; dec_squash[0] = 1; dec_target[0 +: AW] = 32'h3300; cycle();
        cmt_rob_busy[0] = 1; ctx_switch = 1; cycle();
        cycle();

        // R5: decode squash on thread 1
        cur_req = "R5";
        dec_squash[1] = 1; dec_target[AW +: AW] = 32'h4000; cycle();
        dec_squash[1] = 1; dec_target[AW +: AW] = 32'h5000; cycle();
        dec_squash[1] = 1; dec_target[AW +: AW] = 32'h6000; cycle();
        cycle();

        // R10: trap, quiesce, idle
        cur_req = "R10";
        ev_trap[0] = 1; ev_quiesce[0] = 1; cycle();
        ctx_switch = 1; ev_slot[0] = 1; ev_issue[0] = 1; cycle();
        stage_block[2*NT + 0] = 1; cycle();
        stage_unblock[2*NT + 0] = 1; cycle();
        ev_wake[0] = 1; cycle();
        ev_quiesce[0] = 1; cycle();
        ev_resp[0] = 1; cycle();
        cmt_squash[0] = 1; cmt_target[0 +: AW] = 32'h7000; cycle();
        cycle();
        ev_park[0] = 1; ev_retry[0] = 1; cycle();
        ev_slot[0] = 1; cycle();
        ev_wake[0] = 1; cycle();

        // R11: inactive thread 1 frozen
        cur_req = "R11";
        thread_active[1] = 0;
        cmt_squash[1] = 1; cmt_target[AW +: AW] = 32'h8000;
        stage_block[0*NT + 1] = 1; ev_trap[1] = 1; cycle();
        cycle();
        thread_active[1] = 1; cycle();

        // R12: stage activity
        cur_req = "R12";
        ctx_switch = 1; cycle();
        ctx_switch = 1; cycle();
        ev_trap[0] = 1; cycle();
        thread_active[1] = 0; cycle();
        thread_active[1] = 1; ev_wake[0] = 1; cycle();
        cycle();

        // Mixed random traffic
        cur_req = "R7";
        for (int k = 0; k < 3000; k++) begin
            thread_active = '1;
            for (int t = 0; t < NT; t++) begin
                if ($urandom % 16 == 0) thread_active[t] = 0;
                cmt_squash[t]   = ($urandom % 20 == 0);
                cmt_rob_busy[t] = ($urandom % 20 == 0);
                dec_squash[t]   = ($urandom % 12 == 0);
                cmt_target[t*AW +: AW] = {$urandom} & 32'hFFFF_FFFC;
                dec_target[t*AW +: AW] = {$urandom} & 32'hFFFF_FFFC;
                ev_retry[t]   = ($urandom % 6 == 0);
                ev_issue[t]   = ($urandom % 3 == 0);
                ev_resp[t]    = ($urandom % 3 == 0);
                ev_slot[t]    = ($urandom % 3 == 0);
                ev_trap[t]    = ($urandom % 30 == 0);
                ev_quiesce[t] = ($urandom % 30 == 0);
                ev_park[t]    = ($urandom % 30 == 0);
                ev_wake[t]    = ($urandom % 5 == 0);
                for (int g = 0; g < NS; g++) begin
                    stage_block[g*NT + t] = ($urandom % 25 == 0);
                    stage_unblock[g*NT + t] = !stage_block[g*NT + t] && m_flag[g][t] &&
                                              ($urandom % 4 == 0);
                end
            end
            ctx_switch = ($urandom % 40 == 0);
            cycle();
        end
        thread_active = '1;
        report();
    end
endmodule